// File: doc/BRIEF.md
# DMA Channel Transfer Cycle Sequencer

This block runs the bus cycles of a DMA transfer for one channel that has already been granted. Each word moves directly between an I/O device and memory; no data passes through the block. For each word the sequencer steps through four states. S1 sets up the address. S2 opens the read-side strobe. S3 opens the write-side strobe. S4 closes every strobe and updates the address and word count. During S1 it drives the low address byte on its address pins and the high byte on its data-bus output, and pulses an address strobe so that an external latch captures the high byte.

Three transfer kinds are supported. Read moves data from memory to I/O. Write moves data from I/O to memory. Verify walks addresses and counts with every strobe held idle. Compressed timing folds the write strobe into S2 and removes S3. A READY input stretches the strobe state of real transfers. In burst operation the sequencer keeps transferring until terminal count or end-of-process, and it skips S1 whenever the high address byte stays the same from one word to the next.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset the state is idle: aen=0, adstb=0, dack=0, tc=0, and all four strobes (memr_n, memw_n, ior_n, iow_n) are 1.
- R2: The first state after start, and every later S1, drives aen=1 and adstb=1, a_lo=address[7:0], db_hi=address[15:8], and dack one-hot at bit ch. dack stays asserted while aen is 1.
- R3: Read transfer (xfer_type=2'b10): memr_n is low in S2 and S3, and iow_n is low in S3. memw_n and ior_n stay high.
- R4: Write transfer (xfer_type=2'b01): ior_n is low in S2 and S3, and memw_n is low in S3. memr_n and iow_n stay high.
- R5: With compressed=1, S3 is omitted: the write-side strobe is low together with the read-side strobe in S2, and S4 follows S2.
- R6: Verify transfer (xfer_type=2'b00 or 2'b11): all four strobes stay high, READY is ignored, and the address and count advance as in a real transfer.
- R7: For read and write transfers, when ready is 0 at the end of the last strobe state, that state repeats and the strobes stay asserted until ready is sampled 1.
- R8: In S4 all strobes are high. When S4 ends, the count drops by 1 and the address moves by 1: up when addr_down=0, down when addr_down=1.
- R9: With burst=1, S4 goes straight to S2 (aen=1, adstb=0) when the next address has the same bits 15:8. Otherwise the next word starts with S1.
- R10: tc is 1 in the S4 of a word whose count is 0 (the count then wraps to all ones). Service then ends: aen=0 and dack=0 in the next cycle.
- R11: eop_n sampled 0 in S4 raises tc and ends service in the same way, even with burst=1.
- R12: With burst=0, service ends after one word. While idle, load=1 writes load_addr and load_cnt into the current address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load address and count while idle |
| load_addr | input | 16 | Address to load |
| load_cnt | input | 16 | Word count to load |
| start | input | 1 | Begin service of the granted channel |
| ch | input | 2 | Granted channel number |
| xfer_type | input | 2 | 00/11 verify, 01 write, 10 read |
| compressed | input | 1 | Omit S3 |
| burst | input | 1 | Keep transferring until terminal count or end-of-process |
| addr_down | input | 1 | Decrement the address instead of incrementing it |
| ready | input | 1 | Device ready; 0 inserts waits |
| eop_n | input | 1 | External end-of-process, active low |
| aen | output | 1 | Address outputs valid |
| adstb | output | 1 | High-byte latch strobe |
| a_lo | output | 8 | Address bits 7:0 |
| db_hi | output | 8 | Address bits 15:8 during S1, else 0 |
| dack | output | 4 | Channel acknowledge, one-hot |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| tc | output | 1 | Terminal count / end of service |
| cur_addr | output | 16 | Current address register |
| cur_cnt | output | 16 | Current word count register |

## Verification
The bench checks the strobe pattern cycle by cycle for each transfer kind. A swapped memory/I-O pairing would show up as the wrong strobe going low, and a compressed cycle that kept S3 would take one cycle too many. It holds READY low during a verify run and during a read run. A design that let READY stall verify cycles, or that released the strobes early, would show the wrong state count. A burst crosses a 256-byte boundary, so a design that always emitted S1, or that never reissued it, would show the wrong adstb pattern. A zero count and a forced end-of-process check that tc fires in S4 and that service stops even in burst operation.

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int NCH = 4,
  localparam int SW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          start,
  input  logic [SW-1:0] ch,
  input  logic [1:0]    xfer_type,
  input  logic          compressed,
  input  logic          burst,
  input  logic          addr_down,
  input  logic          ready,
  input  logic          eop_n,
  output logic          aen,
  output logic          adstb,
  output logic [7:0]    a_lo,
  output logic [7:0]    db_hi,
  output logic [NCH-1:0] dack,
  output logic          memr_n,
  output logic          memw_n,
  output logic          ior_n,
  output logic          iow_n,
  output logic          tc,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt
);

  typedef enum logic [2:0] {IDLE, S1, S2, S3, S4} st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt;
  logic          hi_ok;
  logic [SW-1:0] ch_q;
  logic [1:0]    typ_q;
  logic          comp_q, burst_q, down_q;

  logic          is_rd, is_wr, real_x, rd_on, wr_on, hold;
  logic [AW-1:0] nxt;

  assign is_rd  = typ_q == 2'b10;
  assign is_wr  = typ_q == 2'b01;
  assign real_x = is_rd | is_wr;
  assign rd_on  = real_x & (st == S2 | st == S3);
  assign wr_on  = real_x & (st == S3 | (st == S2 & comp_q));
  assign hold   = real_x & ~ready;
  assign nxt    = down_q ? addr - 1'b1 : addr + 1'b1;

  assign aen    = st != IDLE;
  assign adstb  = st == S1;
  assign a_lo   = aen ? addr[7:0] : 8'h00;
  assign db_hi  = adstb ? addr[AW-1:AW-8] : 8'h00;
  assign dack   = aen ? (NCH'(1) << ch_q) : '0;
  assign memr_n = ~(rd_on & is_rd);
  assign ior_n  = ~(rd_on & is_wr);
  assign iow_n  = ~(wr_on & is_rd);
  assign memw_n = ~(wr_on & is_wr);
  assign tc     = (st == S4) & ((cnt == '0) | ~eop_n);
  assign cur_addr = addr;
  assign cur_cnt  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      addr    <= '0;
      cnt     <= '0;
      hi_ok   <= 1'b0;
      ch_q    <= '0;
      typ_q   <= 2'b00;
      comp_q  <= 1'b0;
      burst_q <= 1'b0;
      down_q  <= 1'b0;
    end else begin
      case (st)
        IDLE: begin
          hi_ok <= 1'b0;
          if (load) begin
            addr <= load_addr;
            cnt  <= load_cnt;
          end else if (start) begin
            ch_q    <= ch;
            typ_q   <= xfer_type;
            comp_q  <= compressed;
            burst_q <= burst;
            down_q  <= addr_down;
            st      <= S1;
          end
        end
        S1: begin
          hi_ok <= 1'b1;
          st    <= S2;
        end
        S2: begin
          if (comp_q) st <= hold ? S2 : S4;
          else        st <= S3;
        end
        S3: st <= hold ? S3 : S4;
        S4: begin
          addr <= nxt;
          cnt  <= cnt - 1'b1;
          if (tc || !burst_q)                                  st <= IDLE;
          else if (hi_ok && nxt[AW-1:AW-8] == addr[AW-1:AW-8]) st <= S2;
          else                                                 st <= S1;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module dma_xfer_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           aen,
  input logic           adstb,
  input logic [NCH-1:0] dack,
  input logic           memr_n,
  input logic           memw_n,
  input logic           ior_n,
  input logic           iow_n,
  input logic           ready,
  input logic           tc
);

  a_r2_adstb_needs_aen: assert property (@(posedge clk) disable iff (!rst_n)
    adstb |-> aen);

  a_r2_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack) && (aen == (dack != '0)));

  a_r3_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !memr_n |-> (memw_n && ior_n));

  a_r4_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n |-> (memr_n && iow_n));

  a_r7_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!iow_n && !ready) |=> !iow_n);

  a_r8_s4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (aen && memr_n && memw_n && ior_n && iow_n));

  a_r10_tc_ends: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !aen);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .aen(aen), .adstb(adstb), .dack(dack),
  .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
  .ready(ready), .tc(tc)
);

// File: tb/test_dma_xfer_seq.sv
module test_dma_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_addr = '0;
  logic [15:0] load_cnt = '0;
  logic        start = 1'b0;
  logic [1:0]  ch = '0;
  logic [1:0]  xfer_type = 2'b10;
  logic        compressed = 1'b0;
  logic        burst = 1'b0;
  logic        addr_down = 1'b0;
  logic        ready = 1'b1;
  logic        eop_n = 1'b1;
  logic        aen, adstb, memr_n, memw_n, ior_n, iow_n, tc;
  logic [7:0]  a_lo, db_hi;
  logic [3:0]  dack;
  logic [15:0] cur_addr, cur_cnt;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_xfer_seq i_dma_xfer_seq (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
    .load_cnt(load_cnt), .start(start), .ch(ch), .xfer_type(xfer_type),
    .compressed(compressed), .burst(burst), .addr_down(addr_down),
    .ready(ready), .eop_n(eop_n), .aen(aen), .adstb(adstb), .a_lo(a_lo),
    .db_hi(db_hi), .dack(dack), .memr_n(memr_n), .memw_n(memw_n),
    .ior_n(ior_n), .iow_n(iow_n), .tc(tc), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // strobe vector is {memr_n, memw_n, ior_n, iow_n}
  task automatic expect_st(string req, bit e_aen, bit e_adstb, logic [3:0] e_str, bit e_tc);
    chk({req, " aen"}, aen, e_aen);
    chk({req, " adstb"}, adstb, e_adstb);
    chk({req, " strobes"}, {memr_n, memw_n, ior_n, iow_n}, e_str);
    chk({req, " tc"}, tc, e_tc);
  endtask

  task automatic load_regs(logic [15:0] a, logic [15:0] c);
    load_addr = a; load_cnt = c; load = 1'b1;
    step();
    load = 1'b0;
    chk("R12 load addr", cur_addr, a);
    chk("R12 load cnt", cur_cnt, c);
  endtask

  task automatic kick();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic t_reset();
    expect_st("R1", 0, 0, 4'hF, 0);
    chk("R1 dack", dack, 0);
  endtask

  task automatic t_read_single();
    load_regs(16'h1234, 16'd5);
    ch = 2; xfer_type = 2'b10; addr_down = 0;
    kick();
    expect_st("R2 S1", 1, 1, 4'hF, 0);
    chk("R2 a_lo", a_lo, 8'h34);
    chk("R2 db_hi", db_hi, 8'h12);
    chk("R2 dack", dack, 4'b0100);
    step(); expect_st("R3 S2", 1, 0, 4'b0111, 0);
    chk("R2 dack held", dack, 4'b0100);
    step(); expect_st("R3 S3", 1, 0, 4'b0110, 0);
    step(); expect_st("R8 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R12 idle", 0, 0, 4'hF, 0);
    chk("R12 dack off", dack, 0);
    chk("R8 addr up", cur_addr, 16'h1235);
    chk("R8 cnt", cur_cnt, 16'd4);
  endtask

  task automatic t_write_down();
    ch = 1; xfer_type = 2'b01; addr_down = 1;
    kick();
    expect_st("R4 S1", 1, 1, 4'hF, 0);
    chk("R2 dack ch1", dack, 4'b0010);
    step(); expect_st("R4 S2", 1, 0, 4'b1101, 0);
    step(); expect_st("R4 S3", 1, 0, 4'b1001, 0);
    step(); expect_st("R8 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R12 idle", 0, 0, 4'hF, 0);
    chk("R8 addr down", cur_addr, 16'h1234);
    chk("R8 cnt", cur_cnt, 16'd3);
    addr_down = 0;
  endtask

  task automatic t_compressed();
    xfer_type = 2'b10; compressed = 1;
    kick();
    expect_st("R5 S1", 1, 1, 4'hF, 0);
    step(); expect_st("R5 S2 both", 1, 0, 4'b0110, 0);
    step(); expect_st("R5 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R5 idle", 0, 0, 4'hF, 0);
    chk("R5 addr", cur_addr, 16'h1235);
    compressed = 0;
  endtask

  task automatic t_ready_wait();
    xfer_type = 2'b10; ready = 0;
    kick();
    expect_st("R7 S1", 1, 1, 4'hF, 0);
    step(); expect_st("R7 S2", 1, 0, 4'b0111, 0);
    step(); expect_st("R7 S3", 1, 0, 4'b0110, 0);
    step(); expect_st("R7 wait", 1, 0, 4'b0110, 0);
    ready = 1;
    step(); expect_st("R7 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R7 idle", 0, 0, 4'hF, 0);
    chk("R7 addr", cur_addr, 16'h1236);
    chk("R7 cnt", cur_cnt, 16'd1);
  endtask

  task automatic t_verify();
    xfer_type = 2'b00; ready = 0;
    kick();
    expect_st("R6 S1", 1, 1, 4'hF, 0);
    step(); expect_st("R6 S2", 1, 0, 4'hF, 0);
    step(); expect_st("R6 S3", 1, 0, 4'hF, 0);
    step(); expect_st("R6 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R6 idle", 0, 0, 4'hF, 0);
    chk("R6 addr", cur_addr, 16'h1237);
    chk("R6 cnt", cur_cnt, 16'd0);
    ready = 1;
  endtask

  task automatic t_tc_wrap();
    xfer_type = 2'b10;
    kick();
    step(); step(); step();
    expect_st("R10 S4 tc", 1, 0, 4'hF, 1);
    step(); expect_st("R10 ended", 0, 0, 4'hF, 0);
    chk("R10 wrap", cur_cnt, 16'hFFFF);
    chk("R10 dack off", dack, 0);
  endtask

  task automatic t_eop();
    xfer_type = 2'b10; burst = 1; eop_n = 0;
    kick();
    expect_st("R11 S1", 1, 1, 4'hF, 0);
    step(); expect_st("R11 S2", 1, 0, 4'b0111, 0);
    step(); expect_st("R11 S3", 1, 0, 4'b0110, 0);
    step(); expect_st("R11 S4 tc", 1, 0, 4'hF, 1);
    step(); expect_st("R11 ended", 0, 0, 4'hF, 0);
    chk("R11 cnt", cur_cnt, 16'hFFFE);
    eop_n = 1; burst = 0;
  endtask

  task automatic t_burst_skip();
    load_regs(16'h00FE, 16'd2);
    xfer_type = 2'b10; burst = 1;
    kick();
    expect_st("R9 w1 S1", 1, 1, 4'hF, 0);
    step(); step(); step();
    expect_st("R9 w1 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R9 w2 skip S1", 1, 0, 4'b0111, 0);
    chk("R9 w2 a_lo", a_lo, 8'hFF);
    step(); expect_st("R9 w2 S3", 1, 0, 4'b0110, 0);
    step(); expect_st("R9 w2 S4", 1, 0, 4'hF, 0);
    step(); expect_st("R9 w3 S1", 1, 1, 4'hF, 0);
    chk("R9 w3 db_hi", db_hi, 8'h01);
    chk("R9 w3 a_lo", a_lo, 8'h00);
    step(); step(); step();
    expect_st("R10 burst tc", 1, 0, 4'hF, 1);
    step(); expect_st("R10 burst ended", 0, 0, 4'hF, 0);
    chk("R10 burst cnt", cur_cnt, 16'hFFFF);
    burst = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_read_single();
    t_write_down();
    t_compressed();
    t_ready_wait();
    t_verify();
    t_tc_wrap();
    t_eop();
    t_burst_skip();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule